// File: doc/BRIEF.md
# Machine-Check Error Bank Recorder

This block keeps a small array of error-reporting banks for a processor core. Each bank has four 64-bit registers: a control mask, a status word, a captured address and a free-form misc word. Three global registers sit beside the banks: a capability word, a global control mask and a global status word. A hardware error source reports through a one-cycle injection strobe. The strobe carries a bank index, a status word, a global status word, an address, a misc value and an unconditional flag.

For each strobe the block decides one outcome. It may reject the injection outright, or ignore it because a machine check is already being handled. It may drop it because reporting is masked off, or escalate it to a system-reset request. Otherwise it records the error in the bank, with overflow tracking. An uncorrected error that is recorded also pulses the machine-check interrupt. Corrected errors never displace an uncorrected entry that is still valid. Software reads and writes every register through a small flat address map.

Top module: `mca_bank_recorder`

## Requirements
- R1: After reset the registers hold these values. The capability word is the bank count (NBANK) in bits 7:0, with bit 8 set to mean that the global control register exists. The global control and every bank control read all ones. The global status and every bank status, address and misc read zero. All response outputs are low.
- R2: An injection is rejected when any of these holds: the capability word is zero; the bank index is not below capability bits 7:0 or not below NBANK; bit 63 (valid) of the supplied status is clear. A rejection raises `inj_nack` in the cycle after the strobe and changes no register.
- R3: An injection whose status has bit 61 (uncorrected) and bit 55 (action required) both clear is acknowledged but ignored when global status bit 2 (in progress) is set and `inj_uncond` is low. If either status bit is set, or the flag is high, the injection is processed normally.
- R4: An uncorrected injection is acknowledged but dropped, with no register change and no interrupt, in either of two cases. One is capability bit 8 set while the global control is not all ones. The other is the bank's control not all ones.
- R5: An uncorrected injection that is not dropped, arriving while global status bit 2 is set or while `mc_enable` is low, pulses `reset_req` for one cycle one cycle later and records nothing.
- R6: An accepted uncorrected injection does the following. It writes the bank's address and misc. It writes the bank status as the supplied status, with bit 62 (overflow) added if the bank previously held a valid entry. It writes the global status from `inj_gstatus`. It pulses `mc_irq` one cycle after the strobe.
- R7: A corrected injection into a bank whose entry is invalid, or valid but corrected, overwrites status, address and misc. Bit 62 is added if the old entry was valid. There is no interrupt.
- R8: A corrected injection into a bank holding a valid uncorrected entry only sets bit 62 of that bank's status. The address, misc and the rest of the status are kept.
- R9: Exactly one of `inj_ack` or `inj_nack` is high in the cycle after each strobe, and neither is high otherwise. `mc_irq` and `reset_req` are never high together, and each occurs only with `inj_ack`.
- R10: Register map. Address 0 is the capability word, 1 the global control, 2 the global status, and 3 reads zero. Bank i occupies addresses 4(i+1) to 4(i+1)+3, holding control, status, address and misc in that order. Reads are combinational. Writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_enable | input | 1 | Machine-check delivery enabled by the core |
| inj_valid | input | 1 | One-cycle injection strobe |
| inj_bank | input | 8 | Target bank index |
| inj_status | input | 64 | Bank status to record |
| inj_gstatus | input | 64 | Global status to record on an uncorrected error |
| inj_addr | input | 64 | Error address |
| inj_misc | input | 64 | Error misc information |
| inj_uncond | input | 1 | Bypass the in-progress ignore rule |
| inj_ack | output | 1 | Injection passed validation (one cycle after strobe) |
| inj_nack | output | 1 | Injection rejected (one cycle after strobe) |
| mc_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | System-reset request pulse |
| wr_en | input | 1 | Software register write |
| wr_addr | input | ADDR_W | Software write address |
| wr_data | input | 64 | Software write data |
| rd_addr | input | ADDR_W | Software read address |
| rd_data | output | 64 | Software read data |

## Verification
Directed injections come first, one per outcome. They separate a rejection caused by each of its three conditions, an ignore from an action-required or unconditional acceptance, a drop by global mask from a drop by bank mask, and escalation by in-progress from escalation by a disabled core. They also separate an overwrite with overflow from an overflow-only mark on a held uncorrected entry. A long pseudo-random sweep then mixes bank indices from in-range to just out of range with random valid, uncorrected, action-required and unconditional bits. It also toggles masks, in-progress and core enable between strobes, so that outcomes interact across banks. A final scan of the whole map confirms that no bank was touched by an injection aimed elsewhere.

// File: rtl/mca_pkg.sv
package mca_pkg;

    localparam int REG_W     = 64;
    localparam int ST_VALID  = 63;
    localparam int ST_OVER   = 62;
    localparam int ST_UC     = 61;
    localparam int ST_AR     = 55;
    localparam int GS_INPROG = 2;
    localparam int CAP_CTLP  = 8;

    typedef struct packed {
        logic [REG_W-1:0] ctl;
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] misc;
    } bank_regs_t;

    typedef enum logic [2:0] {
        V_NONE,
        V_REJECT,
        V_IGNORE,
        V_DROP,
        V_ESCALATE,
        V_REC_UC,
        V_REC_CE,
        V_MARK_OVER
    } verdict_e;

    typedef enum logic [1:0] {
        F_CTL    = 2'd0,
        F_STATUS = 2'd1,
        F_ADDR   = 2'd2,
        F_MISC   = 2'd3
    } field_e;

    function automatic logic writes_entry(input verdict_e v);
        return (v == V_REC_UC) || (v == V_REC_CE);
    endfunction

endpackage

// File: rtl/mca_verdict.sv
module mca_verdict
    import mca_pkg::*;
#(
    parameter int NBANK = 10
) (
    input  logic             inj_valid,
    input  logic [7:0]       inj_bank,
    input  logic [REG_W-1:0] inj_status,
    input  logic             inj_uncond,
    input  logic             cap_zero,
    input  logic [7:0]       cap_count,
    input  logic             cap_ctlp,
    input  logic             gctl_ones,
    input  logic             in_prog,
    input  logic             mc_enable,
    input  logic             bank_ctl_ones,
    input  logic             old_valid,
    input  logic             old_uc,
    output verdict_e         verdict,
    output logic [REG_W-1:0] new_status
);

    localparam logic [7:0] NB8 = 8'(NBANK);

    logic is_uc, is_ar, bad;

    always_comb begin
        is_uc      = inj_status[ST_UC];
        is_ar      = inj_status[ST_AR];
        bad        = cap_zero || (inj_bank >= cap_count) || (inj_bank >= NB8)
                     || !inj_status[ST_VALID];
        new_status = inj_status;
        verdict    = V_NONE;
        if (inj_valid) begin
            if (bad) begin
                verdict = V_REJECT;
            end else if (!inj_uncond && !is_uc && !is_ar && in_prog) begin
                verdict = V_IGNORE;
            end else if (is_uc) begin
                if ((cap_ctlp && !gctl_ones) || !bank_ctl_ones) begin
                    verdict = V_DROP;
                end else if (in_prog || !mc_enable) begin
                    verdict = V_ESCALATE;
                end else begin
                    verdict = V_REC_UC;
                    if (old_valid) new_status[ST_OVER] = 1'b1;
                end
            end else if (!old_valid || !old_uc) begin
                verdict = V_REC_CE;
                if (old_valid) new_status[ST_OVER] = 1'b1;
            end else begin
                verdict = V_MARK_OVER;
            end
        end
    end

endmodule

// File: rtl/mca_bank_file.sv
module mca_bank_file
    import mca_pkg::*;
#(
    parameter int NBANK = 10,
    parameter int IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  field_e                 wr_field,
    input  logic [REG_W-1:0]       wr_data,
    input  logic [7:0]             cm_bank,
    input  verdict_e               verdict,
    input  logic [REG_W-1:0]       new_status,
    input  logic [REG_W-1:0]       cm_addr,
    input  logic [REG_W-1:0]       cm_misc,
    output bank_regs_t [NBANK-1:0] banks
);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam logic [IDX_W-1:0] MY_IDX  = IDX_W'(g + 1);
        localparam logic [7:0]       MY_BANK = 8'(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                banks[g].ctl    <= '1;
                banks[g].status <= '0;
                banks[g].addr   <= '0;
                banks[g].misc   <= '0;
            end else begin
                if (wr_en && wr_idx == MY_IDX) begin
                    case (wr_field)
                        F_CTL:    banks[g].ctl    <= wr_data;
                        F_STATUS: banks[g].status <= wr_data;
                        F_ADDR:   banks[g].addr   <= wr_data;
                        default:  banks[g].misc   <= wr_data;
                    endcase
                end
                if (cm_bank == MY_BANK) begin
                    if (writes_entry(verdict)) begin
                        banks[g].status <= new_status;
                        banks[g].addr   <= cm_addr;
                        banks[g].misc   <= cm_misc;
                    end else if (verdict == V_MARK_OVER) begin
                        banks[g].status[ST_OVER] <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mca_bank_recorder.sv
module mca_bank_recorder
    import mca_pkg::*;
#(
    parameter int NBANK = 10,
    localparam int ADDR_W = $clog2(4 * NBANK + 4),
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mc_enable,
    input  logic              inj_valid,
    input  logic [7:0]        inj_bank,
    input  logic [63:0]       inj_status,
    input  logic [63:0]       inj_gstatus,
    input  logic [63:0]       inj_addr,
    input  logic [63:0]       inj_misc,
    input  logic              inj_uncond,
    output logic              inj_ack,
    output logic              inj_nack,
    output logic              mc_irq,
    output logic              reset_req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data
);

    logic [REG_W-1:0]       cap_q, gctl_q, gstat_q;
    bank_regs_t [NBANK-1:0] banks;
    logic                   cur_ctl_ones, cur_valid, cur_uc;
    verdict_e               verdict;
    logic [REG_W-1:0]       new_status;
    logic [IDX_W-1:0]       wr_hi, rd_hi;
    logic                   glob_we;

    assign wr_hi   = wr_addr[ADDR_W-1:2];
    assign rd_hi   = rd_addr[ADDR_W-1:2];
    assign glob_we = wr_en && (wr_hi == '0);

    // State of the bank named by the injection
    always_comb begin
        cur_ctl_ones = 1'b0;
        cur_valid    = 1'b0;
        cur_uc       = 1'b0;
        for (int i = 0; i < NBANK; i++) begin
            if (inj_bank == 8'(i)) begin
                cur_ctl_ones = &banks[i].ctl;
                cur_valid    = banks[i].status[ST_VALID];
                cur_uc       = banks[i].status[ST_UC];
            end
        end
    end

    mca_verdict #(.NBANK(NBANK)) u_verdict (
        .inj_valid     (inj_valid),
        .inj_bank      (inj_bank),
        .inj_status    (inj_status),
        .inj_uncond    (inj_uncond),
        .cap_zero      (cap_q == '0),
        .cap_count     (cap_q[7:0]),
        .cap_ctlp      (cap_q[CAP_CTLP]),
        .gctl_ones     (&gctl_q),
        .in_prog       (gstat_q[GS_INPROG]),
        .mc_enable     (mc_enable),
        .bank_ctl_ones (cur_ctl_ones),
        .old_valid     (cur_valid),
        .old_uc        (cur_uc),
        .verdict       (verdict),
        .new_status    (new_status)
    );

    mca_bank_file #(.NBANK(NBANK), .IDX_W(IDX_W)) u_banks (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_idx     (wr_hi),
        .wr_field   (field_e'(wr_addr[1:0])),
        .wr_data    (wr_data),
        .cm_bank    (inj_bank),
        .verdict    (verdict),
        .new_status (new_status),
        .cm_addr    (inj_addr),
        .cm_misc    (inj_misc),
        .banks      (banks)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q   <= REG_W'(NBANK) | (REG_W'(1) << CAP_CTLP);
            gctl_q  <= '1;
            gstat_q <= '0;
        end else begin
            if (glob_we) begin
                case (wr_addr[1:0])
                    2'd0:    cap_q   <= wr_data;
                    2'd1:    gctl_q  <= wr_data;
                    2'd2:    gstat_q <= wr_data;
                    default: ;
                endcase
            end
            if (verdict == V_REC_UC) gstat_q <= inj_gstatus;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inj_ack   <= 1'b0;
            inj_nack  <= 1'b0;
            mc_irq    <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            inj_ack   <= (verdict != V_NONE) && (verdict != V_REJECT);
            inj_nack  <= (verdict == V_REJECT);
            mc_irq    <= (verdict == V_REC_UC);
            reset_req <= (verdict == V_ESCALATE);
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_hi == '0) begin
            case (rd_addr[1:0])
                2'd0:    rd_data = cap_q;
                2'd1:    rd_data = gctl_q;
                2'd2:    rd_data = gstat_q;
                default: rd_data = '0;
            endcase
        end else begin
            for (int i = 0; i < NBANK; i++) begin
                if (rd_hi == IDX_W'(i + 1)) begin
                    case (rd_addr[1:0])
                        2'd0:    rd_data = banks[i].ctl;
                        2'd1:    rd_data = banks[i].status;
                        2'd2:    rd_data = banks[i].addr;
                        default: rd_data = banks[i].misc;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/mca_bank_recorder_chk.sv
module mca_bank_recorder_chk (
    input logic        clk,
    input logic        rst,
    input logic        inj_valid,
    input logic [63:0] inj_status,
    input logic        inj_ack,
    input logic        inj_nack,
    input logic        mc_irq,
    input logic        reset_req
);

    // R9
    ack_nack_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(inj_ack && inj_nack));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(inj_valid) |-> !(inj_ack || inj_nack || mc_irq || reset_req));

    // R9
    strobe_answered_chk: assert property (@(posedge clk) disable iff (rst)
        inj_valid |=> (inj_ack || inj_nack));

    // R9
    irq_rst_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (mc_irq || reset_req) |-> (inj_ack && !(mc_irq && reset_req)));

    // R2
    reject_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (inj_valid && !inj_status[63]) |=> inj_nack);

    // R5
    reset_req_uc_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(inj_status[61]));

    // R6
    irq_uc_chk: assert property (@(posedge clk) disable iff (rst)
        mc_irq |-> $past(inj_status[61]));

endmodule

bind mca_bank_recorder mca_bank_recorder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .inj_valid  (inj_valid),
    .inj_status (inj_status),
    .inj_ack    (inj_ack),
    .inj_nack   (inj_nack),
    .mc_irq     (mc_irq),
    .reset_req  (reset_req)
);

// File: tb/mca_bank_recorder_test.sv
`timescale 1ns/1ps
module mca_bank_recorder_test;

    localparam int NB     = 10;
    localparam int ADDR_W = $clog2(4 * NB + 4);
    localparam logic [63:0] ONES = '1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mc_enable = 1'b1;
    logic              inj_valid = 1'b0;
    logic [7:0]        inj_bank = '0;
    logic [63:0]       inj_status = '0, inj_gstatus = '0, inj_addr = '0, inj_misc = '0;
    logic              inj_uncond = 1'b0;
    logic              inj_ack, inj_nack, mc_irq, reset_req;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [63:0]       wr_data = '0;
    logic [63:0]       rd_data;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model of the register set
    logic [63:0] m_cap, m_gctl, m_gst;
    logic [63:0] m_ctl [NB];
    logic [63:0] m_st  [NB];
    logic [63:0] m_ad  [NB];
    logic [63:0] m_mi  [NB];
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    mca_bank_recorder #(.NBANK(NB)) uut (
        .clk(clk), .rst(rst), .mc_enable(mc_enable),
        .inj_valid(inj_valid), .inj_bank(inj_bank), .inj_status(inj_status),
        .inj_gstatus(inj_gstatus), .inj_addr(inj_addr), .inj_misc(inj_misc),
        .inj_uncond(inj_uncond), .inj_ack(inj_ack), .inj_nack(inj_nack),
        .mc_irq(mc_irq), .reset_req(reset_req), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    task automatic model_reset();
        m_cap  = 64'(NB) | 64'h100;
        m_gctl = ONES;
        m_gst  = '0;
        for (int i = 0; i < NB; i++) begin
            m_ctl[i] = ONES; m_st[i] = '0; m_ad[i] = '0; m_mi[i] = '0;
        end
    endtask

    function automatic logic [63:0] model_read(input int a);
        int hi = a / 4;
        int f  = a % 4;
        if (hi == 0) return (f == 0) ? m_cap : (f == 1) ? m_gctl : (f == 2) ? m_gst : 64'd0;
        if (hi - 1 >= NB) return 64'd0;
        case (f)
            0: return m_ctl[hi-1];
            1: return m_st[hi-1];
            2: return m_ad[hi-1];
            default: return m_mi[hi-1];
        endcase
    endfunction

    task automatic rd_chk(input string tag, input int a);
        rd_addr = ADDR_W'(a);
        #1;
        chk(tag, rd_data, model_read(a));
    endtask

    // R10: software write through the flat map
    task automatic sw_write(input int a, input logic [63:0] d);
        int hi = a / 4;
        int f  = a % 4;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (hi == 0) begin
            if (f == 0) m_cap = d;
            else if (f == 1) m_gctl = d;
            else if (f == 2) m_gst = d;
        end else if (hi - 1 < NB) begin
            case (f)
                0: m_ctl[hi-1] = d;
                1: m_st[hi-1]  = d;
                2: m_ad[hi-1]  = d;
                default: m_mi[hi-1] = d;
            endcase
        end
        rd_chk("R10", a);
    endtask

    task automatic inject(input int b, input logic [63:0] st, input logic [63:0] gs,
                          input logic [63:0] ad, input logic [63:0] mi, input logic unc);
        logic e_ack = 1'b0, e_nack = 1'b0, e_irq = 1'b0, e_rst = 1'b0;
        logic [63:0] old;
        string tag;
        old = (b < NB) ? m_st[b] : 64'd0;
        if (m_cap == 0 || b >= int'(m_cap[7:0]) || b >= NB || !st[63]) begin
            e_nack = 1'b1; tag = "R2";
        end else begin
            e_ack = 1'b1;
            if (!unc && !st[61] && !st[55] && m_gst[2]) begin
                tag = "R3";
            end else if (st[61]) begin
                if ((m_cap[8] && m_gctl != ONES) || m_ctl[b] != ONES) begin
                    tag = "R4";
                end else if (m_gst[2] || !mc_enable) begin
                    tag = "R5"; e_rst = 1'b1;
                end else begin
                    tag = "R6"; e_irq = 1'b1;
                    m_st[b] = st | (old[63] ? 64'h4000_0000_0000_0000 : 64'd0);
                    m_ad[b] = ad; m_mi[b] = mi; m_gst = gs;
                end
            end else if (!old[63] || !old[61]) begin
                tag = "R7";
                m_st[b] = st | (old[63] ? 64'h4000_0000_0000_0000 : 64'd0);
                m_ad[b] = ad; m_mi[b] = mi;
            end else begin
                tag = "R8";
                m_st[b][62] = 1'b1;
            end
        end
        @(negedge clk);
        inj_valid = 1'b1; inj_bank = 8'(b); inj_status = st; inj_gstatus = gs;
        inj_addr = ad; inj_misc = mi; inj_uncond = unc;
        @(negedge clk);
        inj_valid = 1'b0;
        // R9: response one cycle after the strobe
        chk({tag, "/R9 ack"}, 64'(inj_ack), 64'(e_ack));
        chk({tag, "/R9 nack"}, 64'(inj_nack), 64'(e_nack));
        chk({tag, " irq"}, 64'(mc_irq), 64'(e_irq));
        chk({tag, " reset_req"}, 64'(reset_req), 64'(e_rst));
        if (b < NB) begin
            for (int f = 0; f < 4; f++) rd_chk(tag, 4 * (b + 1) + f);
        end
        rd_chk(tag, 2);
    endtask

    localparam logic [63:0] CE  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] UC  = 64'hA000_0000_0000_0000;
    localparam logic [63:0] AR  = 64'h0080_0000_0000_0000;

    initial begin
        #(20.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state of outputs and the whole map
        chk("R1 ack", 64'(inj_ack | inj_nack | mc_irq | reset_req), 64'd0);
        for (int a = 0; a < 4 * NB + 4; a++) rd_chk("R1", a);

        // R2: each rejection cause
        inject(0, 64'h0000_0000_0000_0011, 0, 1, 1, 0);
        inject(NB, CE, 0, 1, 1, 0);
        inject(255, CE, 0, 1, 1, 0);
        sw_write(0, 64'd3);
        inject(5, CE, 0, 1, 1, 0);
        sw_write(0, 64'd0);
        inject(0, CE, 0, 1, 1, 0);
        sw_write(0, 64'(NB) | 64'h100);

        // R7: fresh corrected entries in every bank, then overflow
        for (int b = 0; b < NB; b++) inject(b, CE | 64'(b), 0, 64'h1000 + 64'(b), 64'h20 + 64'(b), 0);
        inject(3, CE | 64'h77, 0, 64'hAAAA, 64'hBBBB, 0);

        // R6: uncorrected onto valid corrected, sets in-progress
        inject(4, UC | 64'h5, 64'h4, 64'hC0DE, 64'h99, 0);
        // R3: ignore, then action-required and unconditional pass
        inject(5, CE | 64'h1, 0, 64'h1, 64'h1, 0);
        inject(5, CE | AR | 64'h2, 0, 64'h2, 64'h2, 0);
        inject(6, CE | 64'h3, 0, 64'h3, 64'h3, 1);
        // R5: uncorrected while in progress
        inject(6, UC, 64'h4, 64'h66, 64'h66, 0);
        sw_write(2, 64'd0);
        // R8: corrected onto held uncorrected
        inject(4, CE | 64'hF, 0, 64'hDEAD, 64'hBEEF, 0);
        // R4: bank mask, then global mask, then no global control
        sw_write(4 * 8, ONES ^ 64'd1);
        inject(7, UC, 0, 64'h7, 64'h7, 0);
        sw_write(4 * 8, ONES);
        sw_write(1, ONES << 1);
        inject(8, UC, 0, 64'h8, 64'h8, 0);
        sw_write(0, 64'(NB));
        inject(8, UC, 0, 64'h8, 64'h8, 0);
        sw_write(0, 64'(NB) | 64'h100);
        sw_write(1, ONES);
        sw_write(2, 64'd0);
        // R5: core delivery disabled
        mc_enable = 1'b0;
        inject(9, UC, 0, 64'h9, 64'h9, 0);
        mc_enable = 1'b1;

        // Near-exhaustive mixed sweep
        for (int k = 0; k < 600; k++) begin
            logic [63:0] r = rnd();
            logic [63:0] st = rnd();
            int b = int'(r[3:0]) % (NB + 2);
            st[63] = (r[7:4] != 0);
            st[61] = r[8];
            st[55] = r[9] & r[10];
            if (k % 7 == 0) sw_write(2, 64'd0);
            if (k % 13 == 0) sw_write(4 * (int'(r[15:12]) % NB + 1), r[16] ? ONES : ONES ^ 64'h80);
            if (k % 29 == 0) sw_write(4 * (int'(r[19:16]) % NB + 1) + 1, 64'd0);
            mc_enable = (r[23:20] != 0);
            inject(b, st, r[24] ? 64'h4 : 64'h1, rnd(), rnd(), r[25] & r[26]);
        end
        mc_enable = 1'b1;

        // R10: full map scan, nothing touched outside the targets
        for (int a = 0; a < 4 * NB + 4; a++) rd_chk("R10", a);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule